// File: doc/BRIEF.md
# Shared Iterative Reciprocal Unit with Round-Robin Arbitration

This block computes the reciprocal of positive fixed-point operands for a group of processing elements that share one divider. Each element owns a request lane and an operand field. An arbiter picks one pending lane at a time in rotating order. The chosen operand and the current scale setting are latched, and a bit-serial divider produces one quotient bit per clock.

The result goes out on a shared result bus together with the index of the lane that asked for it. A single-cycle completion pulse appears only on that lane. Elements that are not yet chosen keep their requests up and wait. The scale input sets the weight of the numerator, so one circuit serves several fixed-point formats. Quotients that do not fit the result width clamp to the largest value. A zero operand also returns the largest value and raises an error flag.

The divider step can be built as a restoring or a non-restoring stage, chosen by a parameter. Both forms give the same quotient.

Top module: `rcp_share`

## Requirements
- R1: While reset is asserted and after it is released with no request pending, `busy` is 0, every `done` lane is 0 and `res_err` is 0.
- R2: For a nonzero operand x and an effective scale s, the result is floor(2^s / x). If that value exceeds 2^RES_W-1, the result is 2^RES_W-1 (all ones). `res_err` is 0 in both cases.
- R3: A zero operand returns all ones on `res_data` with `res_err` = 1 in its completion cycle.
- R4: A `scale` value above 2*OP_W-1 (35 with defaults) is treated as 2*OP_W-1.
- R5: `busy` rises on the clock edge that grants a request and stays high for exactly 2*OP_W cycles (36 with defaults). The completion cycle follows at once, with `busy` low.
- R6: In the completion cycle exactly one `done` bit is set, at the position of the served lane, and `res_idx` carries that lane number. The pulse lasts one cycle.
- R7: A grant takes the first asserted request at or after a pointer, searching upward and wrapping past NUM_PE-1 to 0. The pointer starts at lane 0 after reset and moves to one past the last granted lane.
- R8: The operand and scale are sampled only on the granting edge. Changes to them while `busy` is high do not affect that result.
- R9: No grant is made while `busy` is high. A requester keeps its request until its `done` bit and drops it in that cycle. Pending requests wait, and the next grant may happen on the edge that ends the completion cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NUM_PE | One request bit per processing element |
| opnd_bus | input | NUM_PE*OP_W | Operands; lane i occupies bits [i*OP_W +: OP_W], unsigned |
| scale | input | SH_W | Numerator exponent s, sampled at grant |
| busy | output | 1 | High while a division is in progress |
| done | output | NUM_PE | One-cycle completion pulse on the served lane |
| res_data | output | RES_W | Reciprocal result, valid when a `done` bit is set |
| res_err | output | 1 | Zero-operand flag, valid with `done` |
| res_idx | output | $clog2(NUM_PE) | Lane index of the current result |

## Verification
Single isolated requests with operand 1 at a mid-range scale exercise the exact quotient path. Operand 1 at the top scale forces the clamp. A zero operand separates the error path from ordinary saturation. An out-of-range scale shows clamping of the exponent rather than wrap-around. A burst of all eight lanes raised together shows the rotating order starting after the previously served lane. Two lanes that re-request right after each completion show that neither can take two turns in a row. Changing a lane's operand and the shared scale in mid-division shows that both were captured at the grant. A run of random lanes, operands and scales is compared cycle by cycle against a behavioural queue-free model of the arbitration and the arithmetic.

// File: rtl/rcp_pkg.sv
package rcp_pkg;

   // Selects the arithmetic form of one quotient-bit step
   typedef enum logic [0:0] {
      DIV_RESTORE    = 1'b0,
      DIV_NONRESTORE = 1'b1
   } div_algo_e;

endpackage

// File: rtl/rcp_rr_arb.sv
module rcp_rr_arb #(
   parameter int N  = 8,
   parameter int IW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   input  logic          take,
   output logic          gnt_valid,
   output logic [IW-1:0] gnt_idx
);

   logic [IW-1:0] ptr;

   // Rotated priority search starting at the pointer
   always_comb begin
      gnt_valid = 1'b0;
      gnt_idx   = '0;
      for (int k = 0; k < N; k++) begin
         automatic int j = int'(ptr) + k;
         if (j >= N) j = j - N;
         if (!gnt_valid && req[j]) begin
            gnt_valid = 1'b1;
            gnt_idx   = IW'(j);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (take && gnt_valid) begin
         ptr <= (gnt_idx == IW'(N-1)) ? '0 : gnt_idx + 1'b1;
      end
   end

endmodule

// File: rtl/rcp_iter_div.sv
module rcp_iter_div
   import rcp_pkg::*;
#(
   parameter int        OP_W  = 18,
   parameter int        QUO_W = 2*OP_W,
   parameter int        SH_W  = $clog2(QUO_W),
   parameter div_algo_e ALGO  = DIV_RESTORE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [OP_W-1:0]  dvsr,
   input  logic [SH_W-1:0]  scl,
   output logic             run,
   output logic             fin,
   output logic [QUO_W-1:0] quo
);

   localparam int CW = $clog2(QUO_W);
   localparam logic [CW-1:0] LAST_BIT = CW'(QUO_W-1);

   logic [CW-1:0]   cnt;
   logic [CW-1:0]   scl_q;
   logic [OP_W-1:0] dvsr_q;
   logic            nbit;
   logic            qbit;
   logic            load;
   logic            step;

   assign load = start && !run;
   assign step = run;
   // Numerator is a single one at bit position scl_q
   assign nbit = (cnt == scl_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run    <= 1'b0;
         fin    <= 1'b0;
         cnt    <= '0;
         scl_q  <= '0;
         dvsr_q <= '0;
         quo    <= '0;
      end else begin
         fin <= 1'b0;
         if (load) begin
            run    <= 1'b1;
            cnt    <= LAST_BIT;
            dvsr_q <= dvsr;
            scl_q  <= (scl > SH_W'(QUO_W-1)) ? LAST_BIT : CW'(scl);
            quo    <= '0;
         end else if (step) begin
            quo <= {quo[QUO_W-2:0], qbit};
            if (cnt == '0) begin
               run <= 1'b0;
               fin <= 1'b1;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end
      end
   end

   generate
      if (ALGO == DIV_RESTORE) begin : g_restore
         logic [OP_W-1:0] rem_q;
         logic [OP_W:0]   sh;
         logic [OP_W:0]   diff;

         always_comb begin
            sh   = {rem_q, nbit};
            diff = sh - {1'b0, dvsr_q};
            qbit = ~diff[OP_W];
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     rem_q <= '0;
            else if (load)  rem_q <= '0;
            else if (step)  rem_q <= qbit ? diff[OP_W-1:0] : sh[OP_W-1:0];
         end
      end else begin : g_nonrestore
         logic [OP_W+1:0] rem_q;
         logic [OP_W+1:0] sh;
         logic [OP_W+1:0] nxt;

         always_comb begin
            sh   = {rem_q[OP_W:0], nbit};
            nxt  = rem_q[OP_W+1] ? sh + {2'b00, dvsr_q} : sh - {2'b00, dvsr_q};
            qbit = ~nxt[OP_W+1];
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     rem_q <= '0;
            else if (load)  rem_q <= '0;
            else if (step)  rem_q <= nxt;
         end
      end
   endgenerate

endmodule

// File: rtl/rcp_lane_route.sv
module rcp_lane_route #(
   parameter int N  = 8,
   parameter int IW = $clog2(N)
) (
   input  logic          fin,
   input  logic [IW-1:0] idx,
   output logic [N-1:0]  done
);

   generate
      for (genvar i = 0; i < N; i++) begin : g_lane
         assign done[i] = fin && (idx == IW'(i));
      end
   endgenerate

endmodule

// File: rtl/rcp_share.sv
module rcp_share
   import rcp_pkg::*;
#(
   parameter int        NUM_PE = 8,
   parameter int        OP_W   = 18,
   parameter int        RES_W  = 18,
   parameter int        SH_W   = $clog2(2*OP_W),
   parameter div_algo_e ALGO   = DIV_RESTORE
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_PE-1:0]        req,
   input  logic [NUM_PE*OP_W-1:0]   opnd_bus,
   input  logic [SH_W-1:0]          scale,
   output logic                     busy,
   output logic [NUM_PE-1:0]        done,
   output logic [RES_W-1:0]         res_data,
   output logic                     res_err,
   output logic [$clog2(NUM_PE)-1:0] res_idx
);

   localparam int QUO_W = 2*OP_W;
   localparam int IW    = $clog2(NUM_PE);

   generate
      if (NUM_PE < 2) begin : g_bad_pe
         $error("rcp_share: NUM_PE must be at least 2");
      end
      if (OP_W < 2) begin : g_bad_op
         $error("rcp_share: OP_W must be at least 2");
      end
      if (RES_W > QUO_W || RES_W < 1) begin : g_bad_res
         $error("rcp_share: RES_W must lie in 1..2*OP_W");
      end
      if (SH_W < $clog2(QUO_W)) begin : g_bad_sh
         $error("rcp_share: SH_W too narrow for 2*OP_W scale positions");
      end
   endgenerate

   logic [OP_W-1:0]  opnd_arr [NUM_PE];
   logic             gnt_valid;
   logic [IW-1:0]    gnt_idx;
   logic             take;
   logic             div_run;
   logic             div_fin;
   logic [QUO_W-1:0] quo;
   logic [IW-1:0]    idx_q;
   logic             zero_q;
   logic             ovf;

   generate
      for (genvar i = 0; i < NUM_PE; i++) begin : g_unpack
         assign opnd_arr[i] = opnd_bus[i*OP_W +: OP_W];
      end
   endgenerate

   assign take = gnt_valid && !div_run;

   rcp_rr_arb #(
      .N  (NUM_PE),
      .IW (IW)
   ) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .take      (take),
      .gnt_valid (gnt_valid),
      .gnt_idx   (gnt_idx)
   );

   rcp_iter_div #(
      .OP_W  (OP_W),
      .QUO_W (QUO_W),
      .SH_W  (SH_W),
      .ALGO  (ALGO)
   ) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .start (take),
      .dvsr  (opnd_arr[gnt_idx]),
      .scl   (scale),
      .run   (div_run),
      .fin   (div_fin),
      .quo   (quo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         zero_q <= 1'b0;
      end else if (take) begin
         idx_q  <= gnt_idx;
         zero_q <= (opnd_arr[gnt_idx] == '0);
      end
   end

   generate
      if (QUO_W > RES_W) begin : g_sat
         assign ovf = |quo[QUO_W-1:RES_W];
      end else begin : g_nosat
         assign ovf = 1'b0;
      end
   endgenerate

   rcp_lane_route #(
      .N  (NUM_PE),
      .IW (IW)
   ) u_route (
      .fin  (div_fin),
      .idx  (idx_q),
      .done (done)
   );

   assign busy     = div_run;
   assign res_data = (zero_q || ovf) ? '1 : quo[RES_W-1:0];
   assign res_err  = div_fin && zero_q;
   assign res_idx  = idx_q;

endmodule

// File: rtl/rcp_share_chk.sv
module rcp_share_chk #(
   parameter int NUM_PE = 8,
   parameter int RES_W  = 18,
   parameter int IW     = 3,
   parameter int LAT    = 36
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_PE-1:0] req,
   input logic              busy,
   input logic [NUM_PE-1:0] done,
   input logic [RES_W-1:0]  res_data,
   input logic              res_err,
   input logic [IW-1:0]     res_idx
);

   localparam int CW = $clog2(LAT+1);
   localparam logic [CW-1:0] LAT_C = CW'(LAT);

   logic [CW-1:0] bcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    bcnt <= '0;
      else if (busy) bcnt <= bcnt + 1'b1;
      else           bcnt <= '0;
   end

   // R6
   done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(done));

   // R6
   done_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done != '0) |-> done[res_idx]);

   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done != '0) |=> (done == '0));

   // R5
   done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done != '0) |-> (!busy && bcnt == LAT_C));

   // R5
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (bcnt < LAT_C));

   // R3
   zero_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((done != '0) && res_err) |-> (res_data == '1));

   // R9
   grant_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(req) != '0));

endmodule

bind rcp_share rcp_share_chk #(
   .NUM_PE (NUM_PE),
   .RES_W  (RES_W),
   .IW     ($clog2(NUM_PE)),
   .LAT    (2*OP_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req      (req),
   .busy     (busy),
   .done     (done),
   .res_data (res_data),
   .res_err  (res_err),
   .res_idx  (res_idx)
);

// File: tb/rcp_share_tb.sv
module rcp_share_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NPE    = 8;
   localparam int OPW    = 18;
   localparam int RESW   = 18;
   localparam int SHW    = 6;
   localparam int IW     = 3;
   localparam int LAT    = 36;
   localparam int MAXSCL = 35;
   localparam longint MAXRES = (longint'(1) << RESW) - 1;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [NPE-1:0]       req = '0;
   logic [NPE*OPW-1:0]   opnd_bus = '0;
   logic [SHW-1:0]       scale = '0;
   logic                 busy;
   logic [NPE-1:0]       done;
   logic [RESW-1:0]      res_data;
   logic                 res_err;
   logic [IW-1:0]        res_idx;

   always #(CLK_PERIOD/2) clk = ~clk;

   rcp_share u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req),
      .opnd_bus (opnd_bus),
      .scale    (scale),
      .busy     (busy),
      .done     (done),
      .res_data (res_data),
      .res_err  (res_err),
      .res_idx  (res_idx)
   );

   int  checks = 0;
   int  errors = 0;
   bit  tmo = 1'b0;
   int  cyc = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic longint ref_result(input longint op, input int s);
      longint q;
      if (op == 0) return MAXRES;
      q = (longint'(1) << s) / op;
      return (q > MAXRES) ? MAXRES : q;
   endfunction

   // ---------------- behavioural reference model ----------------
   bit     m_run = 1'b0;
   bit     m_fin = 1'b0;
   int     m_left = 0;
   int     m_idx = 0;
   int     m_ptr = 0;
   longint m_op = 0;
   int     m_scl = 0;
   bit     m_clamped = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_run = 1'b0; m_fin = 1'b0; m_left = 0; m_idx = 0; m_ptr = 0;
      end else begin
         bit fin_n;
         fin_n = 1'b0;
         if (m_run) begin
            if (m_left == 1) begin
               m_run = 1'b0;
               fin_n = 1'b1;
            end else begin
               m_left--;
            end
         end else if (req != '0) begin
            int g;
            g = -1;
            for (int k = 0; k < NPE; k++) begin
               int j;
               j = (m_ptr + k) % NPE;
               if (g < 0 && req[j]) g = j;
            end
            m_idx     = g;
            m_op      = longint'(opnd_bus[g*OPW +: OPW]);
            m_clamped = (int'(scale) > MAXSCL);
            m_scl     = m_clamped ? MAXSCL : int'(scale);
            m_ptr     = (g + 1) % NPE;
            m_left    = LAT;
            m_run     = 1'b1;
         end
         m_fin = fin_n;
      end
   end

   // cycle-by-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         logic [NPE-1:0] exp_done;
         exp_done = m_fin ? (NPE'(1) << m_idx) : '0;
         chk(busy == m_run, "R5", "busy", busy, m_run);
         chk(done == exp_done, "R6", "done lanes", done, exp_done);
         if (m_fin) begin
            if (m_op == 0)
               chk(res_data == RESW'(MAXRES), "R3", "zero operand data", res_data, MAXRES);
            else if (m_clamped)
               chk(res_data == RESW'(ref_result(m_op, m_scl)), "R4", "clamped scale data",
                   res_data, ref_result(m_op, m_scl));
            else
               chk(res_data == RESW'(ref_result(m_op, m_scl)), "R2", "quotient",
                   res_data, ref_result(m_op, m_scl));
            chk(res_err == (m_op == 0), "R3", "error flag", res_err, (m_op == 0));
            chk(int'(res_idx) == m_idx, "R6", "result index", res_idx, m_idx);
         end else begin
            chk(res_err == 1'b0, "R3", "error flag outside completion", res_err, 0);
         end
      end
   end

   // ---------------- requester behaviour and capture ----------------
   int     rerq [NPE];
   bit     pend_re [NPE];
   int     svc_idx [$];
   longint svc_data [$];
   bit     svc_err [$];

   initial begin
      for (int i = 0; i < NPE; i++) begin
         rerq[i] = 0;
         pend_re[i] = 1'b0;
      end
   end

   always @(negedge clk) begin
      for (int i = 0; i < NPE; i++) begin
         if (pend_re[i]) begin
            req[i] = 1'b1;
            pend_re[i] = 1'b0;
         end
      end
      for (int i = 0; i < NPE; i++) begin
         if (done[i]) begin
            req[i] = 1'b0;
            if (rerq[i] > 0) begin
               rerq[i]--;
               pend_re[i] = 1'b1;
            end
            svc_idx.push_back(i);
            svc_data.push_back(longint'(res_data));
            svc_err.push_back(res_err);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) tmo = 1'b1;
   end

   task automatic set_op(input int i, input longint v);
      opnd_bus[i*OPW +: OPW] = OPW'(v);
   endtask

   task automatic ask(input int i, input longint v);
      @(negedge clk);
      set_op(i, v);
      req[i] = 1'b1;
   endtask

   task automatic wait_served(input int n);
      while (svc_idx.size() < n && !tmo) @(negedge clk);
   endtask

   task automatic wait_quiet();
      bit any_pend;
      any_pend = 1'b1;
      while (any_pend && !tmo) begin
         @(negedge clk);
         any_pend = (req != '0) || busy || (done != '0);
         for (int i = 0; i < NPE; i++) if (pend_re[i]) any_pend = 1'b1;
      end
   endtask

   // ---------------- directed and random stimulus ----------------
   initial begin
      int base;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
      chk(done == '0, "R1", "done in reset", done, 0);
      chk(res_err == 1'b0, "R1", "error in reset", res_err, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(busy == 1'b0, "R1", "busy idle after reset", busy, 0);
      chk(done == '0, "R1", "done idle after reset", done, 0);

      // R2: exact power-of-two reciprocal
      base = svc_idx.size();
      scale = SHW'(17);
      ask(3, 1);
      wait_served(base + 1);
      chk(svc_idx[base] == 3, "R6", "served lane", svc_idx[base], 3);
      chk(svc_data[base] == 131072, "R2", "2^17/1", svc_data[base], 131072);
      wait_quiet();

      // R3: zero operand
      base = svc_idx.size();
      scale = SHW'(10);
      ask(0, 0);
      wait_served(base + 1);
      chk(svc_data[base] == MAXRES, "R3", "zero gives max", svc_data[base], MAXRES);
      chk(svc_err[base] == 1'b1, "R3", "zero sets error", svc_err[base], 1);
      wait_quiet();

      // R2: saturation of an oversized quotient
      base = svc_idx.size();
      scale = SHW'(35);
      ask(5, 3);
      wait_served(base + 1);
      chk(svc_data[base] == MAXRES, "R2", "saturated quotient", svc_data[base], MAXRES);
      chk(svc_err[base] == 1'b0, "R2", "no error on saturation", svc_err[base], 0);
      wait_quiet();

      // R4: scale above range clamps to 35
      base = svc_idx.size();
      scale = SHW'(63);
      ask(4, 262143);
      wait_served(base + 1);
      chk(svc_data[base] == 131072, "R4", "scale 63 acts as 35", svc_data[base], 131072);
      wait_quiet();

      // R8: operand and scale changed while busy have no effect
      base = svc_idx.size();
      scale = SHW'(20);
      ask(2, 7);
      repeat (5) @(negedge clk);
      set_op(2, 1);
      scale = SHW'(0);
      wait_served(base + 1);
      chk(svc_data[base] == 149796, "R8", "captured at grant", svc_data[base], 149796);
      wait_quiet();

      // R7: all lanes at once, rotation starts after lane 2
      base = svc_idx.size();
      scale = SHW'(30);
      @(negedge clk);
      for (int i = 0; i < NPE; i++) begin
         set_op(i, 100 + 37 * i);
         req[i] = 1'b1;
      end
      wait_served(base + NPE);
      for (int k = 0; k < NPE; k++) begin
         int want;
         want = (3 + k) % NPE;
         chk(svc_idx[base + k] == want, "R7", "rotation order", svc_idx[base + k], want);
      end
      wait_quiet();

      // R9: two lanes re-requesting at once alternate
      base = svc_idx.size();
      scale = SHW'(25);
      rerq[1] = 1;
      rerq[6] = 1;
      @(negedge clk);
      set_op(1, 9);
      set_op(6, 11);
      req[1] = 1'b1;
      req[6] = 1'b1;
      wait_served(base + 4);
      chk(svc_idx[base]     == 6, "R9", "first turn",  svc_idx[base],     6);
      chk(svc_idx[base + 1] == 1, "R9", "second turn", svc_idx[base + 1], 1);
      chk(svc_idx[base + 2] == 6, "R9", "third turn",  svc_idx[base + 2], 6);
      chk(svc_idx[base + 3] == 1, "R9", "fourth turn", svc_idx[base + 3], 1);
      wait_quiet();

      // random traffic, checked against the model every cycle (R2 R5 R6 R7)
      for (int n = 0; n < 40 && !tmo; n++) begin
         int lane;
         repeat ($urandom_range(0, 40)) @(negedge clk);
         lane = $urandom_range(0, NPE - 1);
         if (!req[lane] && !pend_re[lane]) begin
            set_op(lane, ($urandom_range(0, 7) == 0) ? 0 : $urandom_range(1, 262143));
            scale = SHW'($urandom_range(0, 63));
            req[lane] = 1'b1;
         end
      end
      wait_quiet();
      repeat (3) @(negedge clk);

      if (tmo) begin
         checks++;
         errors++;
         $display("FAIL watchdog run did not complete actual=%0d expected=%0d", cyc, 100000);
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   // hard stop if the stimulus itself hangs
   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog hard stop actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule